// File: doc/BRIEF.md
# Bus Requester with Release Lockout

This block asks an external arbiter for a shared local bus on behalf of one internal master. It raises a request output when the master has a transfer pending and samples the arbiter's grant input. Once grant is seen while its own request is up, it tells the master that the bus is owned. When the master reports that the transfer has finished, the block drops the request and ownership together.

After each release the block holds its request low for a programmable window of (setting + 1) clock periods, where the setting is a 3-bit value from 0 to 7. An arbiter withdraws grant only after request has gone low, and the delay between the two depends on the system. The window stops a grant that is still asserted from an earlier ownership from being taken as a new approval. The window is counted on the block's own clock, so any gating of a clock driven off chip has no effect on it. The setting is captured at the moment of release, and changes to it during a window apply only to later windows.

The controller has four states:
- IDLE: no request.
- REQUEST: request high, waiting for grant.
- OWNED: request and ownership high.
- LOCKOUT: request low, window counting.

It has six transitions:
- IDLE→REQUEST when a transfer is pending.
- REQUEST→OWNED when grant is sampled high.
- OWNED→LOCKOUT when the transfer is done.
- LOCKOUT→REQUEST when the window has ended and a transfer is pending.
- LOCKOUT→IDLE when the window has ended and nothing is pending.
- Any state→IDLE on reset.

Top module: `bus_requester`

## Requirements
- R1: A synchronous active-high reset drives `bus_req` and `bus_owned` low after the next clock edge. It also clears the lockout count, so a transfer pending right after reset raises `bus_req` one edge later.
- R2: In IDLE, a high `xfer_pending` sampled at a clock edge makes `bus_req` high after that edge. A low `xfer_pending` keeps `bus_req` low.
- R3: In REQUEST, a high `bus_grant` sampled at an edge makes `bus_owned` high after that edge, and `bus_req` stays high. A low `bus_grant` keeps `bus_owned` low.
- R4: `bus_owned` is never high while `bus_req` is low.
- R5: In OWNED, a high `xfer_done` sampled at an edge makes both `bus_req` and `bus_owned` low after that edge.
- R6: After a release, `bus_req` stays low for exactly `lapse_cfg`+1 clock periods, where `lapse_cfg` is the value sampled at the releasing edge. If `xfer_pending` is high, `bus_req` rises in the period that follows. A setting of 0 gives one low period and a setting of 7 gives eight.
- R7: The setting is sampled only at the releasing edge. Changing `lapse_cfg` during a window does not change that window's length.
- R8: During the lockout window a high `bus_grant` has no effect: `bus_owned` and `bus_req` stay low.
- R9: If `xfer_pending` is low when the window ends, the block goes to IDLE with `bus_req` low. A later pending transfer raises `bus_req` one edge after it is sampled.
- R10: `xfer_done` has no effect outside OWNED. In REQUEST and IDLE the outputs are unchanged by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock; all counting runs on it |
| rst | input | 1 | Synchronous active-high reset |
| lapse_cfg | input | 3 | Lockout setting; the window is setting+1 periods |
| xfer_pending | input | 1 | Internal master has a transfer waiting |
| xfer_done | input | 1 | Internal master finished its transfer |
| bus_grant | input | 1 | Grant from the external arbiter |
| bus_req | output | 1 | Request to the external arbiter |
| bus_owned | output | 1 | Tells the internal master it owns the bus |

## Verification
The assertions check the following on every cycle:
- Ownership implies request.
- A sampled grant in REQUEST leads to ownership.
- A done in OWNED drops both outputs.
- The lockout counter loads the captured setting and counts down by one without wrapping.
- Request stays low while the counter is non-zero.

The exact window length for a given setting is shown only by the bench's scenarios. So are the immunity to mid-window setting changes and to a stale grant, the return to IDLE when nothing is pending, and the effect of a reset during ownership. The bench checks these edge by edge against expected output pairs.

// File: rtl/brq_pkg.sv
package brq_pkg;
    typedef enum logic [1:0] {
        BRQ_IDLE    = 2'd0,
        BRQ_REQUEST = 2'd1,
        BRQ_OWNED   = 2'd2,
        BRQ_LOCKOUT = 2'd3
    } brq_state_e;
endpackage

// File: rtl/brq_lockout_timer.sv
module brq_lockout_timer #(
    parameter int LAPSE_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [LAPSE_W-1:0] load_val,
    output logic               expired
);
    localparam logic [LAPSE_W-1:0] CNT_ZERO = '0;
    localparam logic [LAPSE_W-1:0] CNT_ONE  = {{(LAPSE_W-1){1'b0}}, 1'b1};

    logic [LAPSE_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= CNT_ZERO;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != CNT_ZERO) begin
            cnt <= cnt - CNT_ONE;
        end
    end

    assign expired = (cnt == CNT_ZERO);

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt == $past(load_val)); // R7
    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != CNT_ZERO) |=> cnt == $past(cnt) - CNT_ONE); // R6
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt == CNT_ZERO) |=> cnt == CNT_ZERO); // R9
endmodule

// File: rtl/brq_fsm.sv
module brq_fsm
    import brq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic xfer_pending,
    input  logic xfer_done,
    input  logic bus_grant,
    input  logic lock_expired,
    output logic lock_load,
    output logic bus_req,
    output logic bus_owned
);
    brq_state_e state;
    brq_state_e state_nxt;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= BRQ_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        lock_load = 1'b0;
        unique case (state)
            BRQ_IDLE: begin
                if (xfer_pending) state_nxt = BRQ_REQUEST;
            end
            BRQ_REQUEST: begin
                if (bus_grant) state_nxt = BRQ_OWNED;
            end
            BRQ_OWNED: begin
                if (xfer_done) begin
                    state_nxt = BRQ_LOCKOUT;
                    lock_load = 1'b1;
                end
            end
            BRQ_LOCKOUT: begin
                if (lock_expired) begin
                    state_nxt = xfer_pending ? BRQ_REQUEST : BRQ_IDLE;
                end
            end
            default: state_nxt = BRQ_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        bus_req   = 1'b0;
        bus_owned = 1'b0;
        unique case (state)
            BRQ_IDLE:    ;
            BRQ_REQUEST: bus_req = 1'b1;
            BRQ_OWNED: begin
                bus_req   = 1'b1;
                bus_owned = 1'b1;
            end
            BRQ_LOCKOUT: ;
            default:     ;
        endcase
    end

    AST_GRANT_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (state == BRQ_REQUEST && bus_grant) |=> bus_owned); // R3
    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (bus_owned && xfer_done) |=> (!bus_req && !bus_owned)); // R5
    AST_WINDOW_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state == BRQ_LOCKOUT && !lock_expired) |=> state == BRQ_LOCKOUT); // R6
    AST_STALE_GRANT: assert property (@(posedge clk) disable iff (rst)
        (state == BRQ_LOCKOUT && !lock_expired && bus_grant) |=> !bus_owned); // R8
endmodule

// File: rtl/bus_requester.sv
module bus_requester #(
    parameter int LAPSE_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [LAPSE_W-1:0] lapse_cfg,
    input  logic               xfer_pending,
    input  logic               xfer_done,
    input  logic               bus_grant,
    output logic               bus_req,
    output logic               bus_owned
);
    logic lock_load;
    logic lock_expired;

    brq_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .xfer_pending (xfer_pending),
        .xfer_done    (xfer_done),
        .bus_grant    (bus_grant),
        .lock_expired (lock_expired),
        .lock_load    (lock_load),
        .bus_req      (bus_req),
        .bus_owned    (bus_owned)
    );

    brq_lockout_timer #(.LAPSE_W(LAPSE_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (lock_load),
        .load_val (lapse_cfg),
        .expired  (lock_expired)
    );

    AST_OWN_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        bus_owned |-> bus_req); // R4
    AST_LOCK_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        !lock_expired |-> !bus_req); // R6
endmodule

// File: tb/tb_bus_requester.sv
module tb_bus_requester;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] lapse_cfg = 3'd0;
    logic       xfer_pending = 1'b0;
    logic       xfer_done = 1'b0;
    logic       bus_grant = 1'b0;
    logic       bus_req;
    logic       bus_owned;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    typedef struct {
        logic  req;
        logic  own;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    always #10 clk = ~clk; // 50 MHz

    bus_requester dut (
        .clk          (clk),
        .rst          (rst),
        .lapse_cfg    (lapse_cfg),
        .xfer_pending (xfer_pending),
        .xfer_done    (xfer_done),
        .bus_grant    (bus_grant),
        .bus_req      (bus_req),
        .bus_owned    (bus_owned)
    );

    // Driver: drive inputs at the falling edge, queue the outputs expected after the next rising edge
    task automatic step(input logic r, input logic pend, input logic done, input logic gnt,
                        input logic [2:0] cfg, input logic e_req, input logic e_own, input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; xfer_pending = pend; xfer_done = done; bus_grant = gnt; lapse_cfg = cfg;
        e.req = e_req; e.own = e_own; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compare shortly after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                vectors++;
                if (bus_req !== e.req || bus_owned !== e.own) begin
                    miscompares++;
                    $display("FAIL %s: req/own = %b/%b, expected %b/%b",
                             e.tag, bus_req, bus_owned, e.req, e.own);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: run hung, actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        step(1, 0, 0, 0, 3'd0, 0, 0, "R1 reset");
        step(1, 1, 0, 1, 3'd0, 0, 0, "R1 reset held");
        // R1/R2 immediate request after reset
        step(0, 1, 0, 0, 3'd0, 1, 0, "R1 R2 request after reset");
        // R3 no grant keeps ownership low
        step(0, 1, 0, 0, 3'd0, 1, 0, "R3 no grant");
        // R10 done in REQUEST ignored
        step(0, 1, 1, 0, 3'd0, 1, 0, "R10 done in request");
        step(0, 1, 0, 1, 3'd0, 1, 1, "R3 grant taken");
        step(0, 1, 0, 1, 3'd0, 1, 1, "R4 owned holds");
        // R5 release with setting 0
        step(0, 1, 1, 1, 3'd0, 0, 0, "R5 release");
        // R6 one period low, then request with stale grant high
        step(0, 1, 0, 1, 3'd7, 1, 0, "R6 setting0 rerequest");
        step(0, 1, 0, 1, 3'd7, 1, 1, "R3 regrant");
        // R6/R8 setting 5: six low periods with grant still high
        step(0, 1, 1, 1, 3'd5, 0, 0, "R5 release s5");
        for (int i = 0; i < 5; i++) step(0, 1, 0, 1, 3'd5, 0, 0, "R8 stale grant in window s5");
        step(0, 1, 0, 1, 3'd5, 1, 0, "R6 s5 rerequest");
        step(0, 1, 0, 1, 3'd5, 1, 1, "R3 grant s5");
        // R7 setting 2 captured, changed to 7 during window
        step(0, 1, 1, 0, 3'd2, 0, 0, "R7 release s2");
        step(0, 1, 0, 0, 3'd7, 0, 0, "R7 window s2 a");
        step(0, 1, 0, 0, 3'd0, 0, 0, "R7 window s2 b");
        step(0, 1, 0, 0, 3'd7, 1, 0, "R7 s2 rerequest");
        step(0, 1, 0, 1, 3'd7, 1, 1, "R3 grant s2");
        // R6 setting 7: eight low periods
        step(0, 1, 1, 0, 3'd7, 0, 0, "R6 release s7");
        for (int i = 0; i < 7; i++) step(0, 1, 0, 0, 3'd7, 0, 0, "R6 window s7");
        step(0, 1, 0, 0, 3'd7, 1, 0, "R6 s7 rerequest");
        step(0, 0, 0, 1, 3'd7, 1, 1, "R3 grant s7");
        // R9 nothing pending at window end
        step(0, 0, 1, 1, 3'd1, 0, 0, "R9 release s1");
        step(0, 0, 0, 1, 3'd1, 0, 0, "R9 window s1");
        step(0, 0, 0, 1, 3'd1, 0, 0, "R9 to idle");
        step(0, 0, 1, 1, 3'd1, 0, 0, "R10 done in idle");
        step(0, 0, 0, 1, 3'd1, 0, 0, "R2 idle no pending");
        step(0, 1, 0, 1, 3'd1, 1, 0, "R9 R2 later request");
        step(0, 1, 0, 1, 3'd1, 1, 1, "R3 grant after idle");
        // R1 reset during ownership, then immediate request
        step(1, 1, 0, 1, 3'd3, 0, 0, "R1 reset while owned");
        step(0, 1, 0, 0, 3'd3, 1, 0, "R1 request after reset");
        step(0, 0, 0, 0, 3'd3, 1, 0, "R2 drain");
        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule